// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave keeps stuck by holding SDA low after a transfer was cut short. When it receives a start strobe, it takes the two open-drain pad enables away from the normal bus controller. It releases both lines for one half period. It then clocks SCL low and high nine times, so that any slave still in the middle of a byte can shift out its remaining bits and let go of SDA. It finishes with a bus-reset pattern in which SDA is pulled low while SCL stays released and SDA is then let go, which places a STOP condition on the wire. At the end it hands the pads back to the controller.

The half-period length is given in clock cycles on an input and is captured when the strobe is accepted. During every released-high level of the nine pulses, the sequencer watches the sensed SCL line and does not count high time while a slave stretches the clock. Deciding when recovery is needed, for example from a bus-busy flag that never clears, happens outside this block. A busy output covers the whole run, and a one-cycle done pulse marks its end.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0. While busy_o is 0, scl_oe_o equals ctl_scl_oe_i and sda_oe_o equals ctl_sda_oe_i. An output enable of 1 pulls the line low and 0 releases it.
- R2: A start_i strobe sampled while idle makes busy_o 1 from the next cycle. For the first half period, both scl_oe_o and sda_oe_o are 0, whatever the controller enables are.
- R3: The prepare level is followed by exactly nine SCL pulses, each one written as {scl_oe_o,sda_oe_o}: a low level of 2'b10 for one half period, then a released level of 2'b00 for one half period.
- R4: During the released level of a pulse, a cycle in which scl_in_i is sensed low does not count toward that level, so the level is lengthened by one cycle for each stretched cycle.
- R5: After the ninth pulse, the pattern is 2'b01 for one half period and then 2'b00 for one half period. SDA therefore rises while SCL is released, which is a STOP.
- R6: While busy_o is 1, the sequencer never pulls SDA low while it is pulling SCL low.
- R7: busy_o stays 1 for exactly 21*L cycles plus the stretched cycles, where L is the captured half period. done_o is 1 for exactly one cycle, the first cycle in which busy_o is 0 again.
- R8: While busy_o is 1, a start_i strobe and any change of half_period_i have no effect on the running sequence.
- R9: A captured half period of 0 behaves as a half period of 1.
- R10: From the cycle in which done_o is 1, the pad enables follow the controller enables again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a recovery run |
| half_period_i | input | CNT_W | Half-period length in clock cycles |
| ctl_scl_oe_i | input | 1 | SCL pull-low enable from the normal controller |
| ctl_sda_oe_i | input | 1 | SDA pull-low enable from the normal controller |
| scl_in_i | input | 1 | Sensed SCL pad level |
| scl_oe_o | output | 1 | SCL pull-low enable to the pad |
| sda_oe_o | output | 1 | SDA pull-low enable to the pad |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The hardest situation to reach from the ports is a slave that stretches SCL during one particular pulse while the rest of the run keeps its nominal timing. A second hard case is a start strobe or a new half period that arrives in the middle of a run. The bench models the pad as wired-AND, counts the SCL release edges it observes, and holds the sensed SCL low for a random number of cycles on a chosen pulse. On selected runs it also pulses start and changes the half period halfway through. Each run is compared, cycle by cycle, with a pad waveform that the bench builds itself.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  // Phases of the recovery sequence, in the order they are visited
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PREP    = 3'd1,
    PH_LOW     = 3'd2,
    PH_HIGH    = 3'd3,
    PH_SDA_LOW = 3'd4,
    PH_RELEASE = 3'd5
  } phase_e;

  // Pull-low enables for the two bus lines (1 = pull low)
  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;

  // Pad pattern the sequencer drives in each phase
  function automatic line_pair_t phase_drive(phase_e ph);
    line_pair_t d;
    d = '0;
    case (ph)
      PH_LOW:     d.scl = 1'b1;
      PH_SDA_LOW: d.sda = 1'b1;
      default:    d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  input  logic             hold_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  // A zero length is treated as one cycle
  function automatic logic [CNT_W-1:0] reload_value(logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - CNT_W'(1);
  endfunction

  assign expire_o = run_i && !hold_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload_value(len_i);
    end else if (run_i && !hold_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/rcv_pulse_count.sv
module rcv_pulse_count #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);

  localparam int PW = $clog2(NUM_PULSES + 1);

  logic [PW-1:0] cnt_q;

  assign last_o = (cnt_q == PW'(NUM_PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

endmodule

// File: rtl/rcv_phase_fsm.sv
module rcv_phase_fsm
  import rcv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   expire_i,
  input  logic   last_pulse_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   advance_o,
  output logic   pulse_done_o,
  output logic   finish_o
);

  phase_e phase_q, phase_d;

  assign phase_o      = phase_q;
  assign accept_o     = (phase_q == PH_IDLE) && start_i;
  assign advance_o    = (phase_q != PH_IDLE) && expire_i;
  assign pulse_done_o = (phase_q == PH_HIGH) && expire_i;
  assign finish_o     = (phase_q == PH_RELEASE) && expire_i;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:    if (start_i)  phase_d = PH_PREP;
      PH_PREP:    if (expire_i) phase_d = PH_LOW;
      PH_LOW:     if (expire_i) phase_d = PH_HIGH;
      PH_HIGH:    if (expire_i) phase_d = last_pulse_i ? PH_SDA_LOW : PH_LOW;
      PH_SDA_LOW: if (expire_i) phase_d = PH_RELEASE;
      PH_RELEASE: if (expire_i) phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/rcv_pad_mux.sv
module rcv_pad_mux #(
  parameter int LANES = 2
) (
  input  logic             ovr_i,
  input  logic [LANES-1:0] seq_oe_i,
  input  logic [LANES-1:0] ctl_oe_i,
  output logic [LANES-1:0] pad_oe_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pad_oe_o[g] = ovr_i ? seq_oe_i[g] : ctl_oe_i[g];
  end

endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
  import rcv_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NUM_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] half_period_i,
  input  logic             ctl_scl_oe_i,
  input  logic             ctl_sda_oe_i,
  input  logic             scl_in_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o
);

  // Named internal events
  phase_e           phase;
  logic             start_accept;
  logic             phase_advance;
  logic             pulse_step;
  logic             seq_finish;
  logic             timer_expire;
  logic             last_pulse;
  logic             stretch_hold;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_sel;
  logic             done_q;
  line_pair_t       seq_drive;
  logic [1:0]       pad_oe;

  assign busy_o       = (phase != PH_IDLE);
  assign stretch_hold = (phase == PH_HIGH) && !scl_in_i;
  assign len_sel      = start_accept ? half_period_i : len_q;
  assign seq_drive    = phase_drive(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (start_accept) len_q <= half_period_i;
      done_q <= seq_finish;
    end
  end

  assign done_o = done_q;

  rcv_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .expire_i     (timer_expire),
    .last_pulse_i (last_pulse),
    .phase_o      (phase),
    .accept_o     (start_accept),
    .advance_o    (phase_advance),
    .pulse_done_o (pulse_step),
    .finish_o     (seq_finish)
  );

  rcv_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_accept || phase_advance),
    .len_i    (len_sel),
    .run_i    (busy_o),
    .hold_i   (stretch_hold),
    .expire_o (timer_expire)
  );

  rcv_pulse_count #(.NUM_PULSES(NUM_PULSES)) u_pulses (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_accept),
    .step_i  (pulse_step),
    .last_o  (last_pulse)
  );

  rcv_pad_mux #(.LANES(2)) u_mux (
    .ovr_i    (busy_o),
    .seq_oe_i ({seq_drive.scl, seq_drive.sda}),
    .ctl_oe_i ({ctl_scl_oe_i, ctl_sda_oe_i}),
    .pad_oe_o (pad_oe)
  );

  assign scl_oe_o = pad_oe[1];
  assign sda_oe_o = pad_oe[0];

endmodule

// File: rtl/rcv_checker.sv
module rcv_checker #(
  parameter int NUM_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ctl_scl_oe_i,
  input logic ctl_sda_oe_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic phase_advance
);

  logic       prev_scl_q;
  logic [7:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl_q <= 1'b0;
      seen_q     <= '0;
    end else begin
      prev_scl_q <= scl_oe_o;
      if (!busy_o)                      seen_q <= '0;
      else if (scl_oe_o && !prev_scl_q) seen_q <= seen_q + 8'd1;
    end
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_oe_o == ctl_scl_oe_i) && (sda_oe_o == ctl_sda_oe_i));

  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o && !scl_oe_o && !sda_oe_o);

  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> seen_q <= 8'(NUM_PULSES));

  assert_pulse_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> seen_q == 8'(NUM_PULSES));

  assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $fell(sda_oe_o) |-> !scl_oe_o);

  assert_sda_vs_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && sda_oe_o |-> !scl_oe_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !phase_advance |=> busy_o && $stable(scl_oe_o) && $stable(sda_oe_o));

endmodule

bind i2c_unstick_seq rcv_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .ctl_scl_oe_i  (ctl_scl_oe_i),
  .ctl_sda_oe_i  (ctl_sda_oe_i),
  .scl_oe_o      (scl_oe_o),
  .sda_oe_o      (sda_oe_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .phase_advance (phase_advance)
);

// File: tb/sim_i2c_unstick_seq.sv
`timescale 1ns/1ps
module sim_i2c_unstick_seq;

  localparam int CNT_W = 16;
  localparam int NP    = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] hp = '0;
  logic             ctl_scl = 1'b0;
  logic             ctl_sda = 1'b0;
  logic             stretch_on = 1'b0;
  logic             scl_oe, sda_oe, busy, done;
  logic             scl_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0] exp_w [0:4095];
  int         exp_n;

  always #2.5 clk = ~clk;

  // Wired-AND pad: low if the block pulls it or a slave stretches it
  assign scl_in = !(scl_oe || stretch_on);

  i2c_unstick_seq #(.CNT_W(CNT_W), .NUM_PULSES(NP)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .half_period_i (hp),
    .ctl_scl_oe_i  (ctl_scl),
    .ctl_sda_oe_i  (ctl_sda),
    .scl_in_i      (scl_in),
    .scl_oe_o      (scl_oe),
    .sda_oe_o      (sda_oe),
    .busy_o        (busy),
    .done_o        (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int eff_half(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  task automatic push(input int cnt, input logic [1:0] pat);
    for (int i = 0; i < cnt; i++) begin
      exp_w[exp_n] = pat;
      exp_n++;
    end
  endtask

  // Expected {scl_oe, sda_oe} per busy cycle
  task automatic build_exp(input int h, input int sp, input int k);
    int e;
    e = eff_half(h);
    exp_n = 0;
    push(e, 2'b00);
    for (int p = 0; p < NP; p++) begin
      push(e, 2'b10);
      push(e + ((p == sp) ? k : 0), 2'b00);
    end
    push(e, 2'b01);
    push(e, 2'b00);
  endtask

  task automatic run(input int h, input int sp, input int k, input bit poke, input string tag);
    int idx, falls, mism, bad_at, left;
    logic [1:0] bad_act;
    logic prev_scl;
    build_exp(h, sp, k);
    @(negedge clk);
    hp = CNT_W'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; falls = 0; mism = 0; bad_at = -1; left = 0; prev_scl = 1'b0;
    bad_act = 2'b00;
    while (busy && idx < 4000) begin
      if (left > 0) begin
        left--;
        if (left == 0) stretch_on = 1'b0;
      end
      if (idx >= exp_n || {scl_oe, sda_oe} != exp_w[idx]) begin
        mism++;
        if (bad_at < 0) begin
          bad_at = idx;
          bad_act = {scl_oe, sda_oe};
        end
      end
      if (prev_scl && !scl_oe) begin
        falls++;
        if (falls == sp + 1 && k > 0) begin
          left = k;
          stretch_on = 1'b1;
        end
      end
      prev_scl = scl_oe;
      if (poke && idx == exp_n / 2) begin
        start = 1'b1;
        hp = CNT_W'(1 + $urandom % 40);
      end else begin
        start = 1'b0;
      end
      ctl_scl = 1'($urandom);
      ctl_sda = 1'($urandom);
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    stretch_on = 1'b0;
    if (idx >= 4000) chk(1'b0, "R7", {tag, " watchdog busy stuck"}, idx, exp_n);
    chk(idx == 21 * eff_half(h) + k, "R7", {tag, " busy length"}, idx, 21 * eff_half(h) + k);
    chk(mism == 0, poke ? "R8" : "R3/R4/R5", {tag, " pad waveform, first bad cycle"},
        (bad_at < 0) ? 0 : bad_at * 4 + int'(bad_act), (bad_at < 0) ? 0 : bad_at * 4 + int'(exp_w[bad_at]));
    chk(done == 1'b1, "R7", {tag, " done at end"}, int'(done), 1);
    chk(scl_oe == ctl_scl && sda_oe == ctl_sda, "R10", {tag, " handback on done"},
        int'({scl_oe, sda_oe}), int'({ctl_scl, ctl_sda}));
    ctl_scl = 1'($urandom);
    ctl_sda = 1'($urandom);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", {tag, " done single cycle"}, int'({busy, done}), 0);
    chk(scl_oe == ctl_scl && sda_oe == ctl_sda, "R10", {tag, " pass-through after"},
        int'({scl_oe, sda_oe}), int'({ctl_scl, ctl_sda}));
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset state busy/done", int'({busy, done}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ctl_scl = 1'($urandom);
      ctl_sda = 1'($urandom);
      @(negedge clk);
      chk(scl_oe == ctl_scl && sda_oe == ctl_sda, "R1", "idle pass-through",
          int'({scl_oe, sda_oe}), int'({ctl_scl, ctl_sda}));
    end

    // R2: first cycle after start releases both lines even if controller pulls
    @(negedge clk);
    ctl_scl = 1'b1; ctl_sda = 1'b1; hp = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && scl_oe == 1'b0 && sda_oe == 1'b0, "R2", "prepare level",
        int'({busy, scl_oe, sda_oe}), 4);
    while (busy) @(negedge clk);
    @(negedge clk);

    run(1, 9, 0, 1'b0, "R3 h=1");
    run(0, 9, 0, 1'b0, "R9 h=0");
    run(3, 0, 5, 1'b0, "R4 stretch first");
    run(2, 8, 3, 1'b0, "R4 stretch last");
    run(4, 9, 0, 1'b1, "R8 start while busy");
    for (int r = 0; r < 10; r++) begin
      run(1 + int'($urandom % 12), int'($urandom % 9), int'($urandom % 6),
          1'($urandom), "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule